// File: doc/BRIEF.md
# Machine-Cycle Watchdog with Keyed Arming

This block is a watchdog timer for a small 8-bit controller core. It listens on the core's special-function-register write bus. It counts machine cycles, which arrive as a one-clock strobe on the oscillator clock. If software stops servicing it, the block raises a reset request and drives a stretched reset-out pulse.

The watchdog starts disabled. Software arms it with two writes in a row to the key register: an opening byte, then a closing byte. The same pair of writes later restarts the count. Once armed, the watchdog cannot be turned off by software. Only an external reset, or the watchdog's own overflow, returns it to the disabled state. The count itself is hidden: it cannot be read, and no write loads it.

A single flag in the auxiliary register lets software prevent the reset-out drive. The reset request is still raised when that flag is set.

Top module: `mcu_watchdog`

## Requirements
- R1: After external reset the watchdog is disarmed, its hidden count is zero, the suppress flag is 0, and both `rst_pin_drive` and `wdt_reset_req` are low.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 to 0xA6, arms the watchdog and clears its count at the clock edge of the second write. Idle cycles and writes to other addresses between the two writes do not break the pair, and repeating 0x1E keeps the pair open.
- R3: Completing the same pair while armed restarts the count from zero. A restart that lands on the same edge as the final machine-cycle strobe takes priority, and no overflow occurs.
- R4: While armed, the count advances by one on each clock edge where `mc_tick` is 1 and holds otherwise. Overflow happens on the strobe that arrives while the count is 0x3FFF, which is the 16384th strobe after arming when no restart intervenes.
- R5: No write disarms the watchdog once it is armed. This covers any value written to 0xA6 and any value written to 0x8E.
- R6: When the pair is open, a write to 0xA6 of any value other than 0xE1 or 0x1E closes it. A later 0xE1 then has no effect.
- R7: On overflow, `wdt_reset_req` is high for exactly one clock, on the cycle after the overflow edge. The watchdog is left disarmed with a zero count.
- R8: On overflow with the suppress flag at 0, `rst_pin_drive` goes high on the cycle after the overflow edge and stays high for exactly 98 clocks.
- R9: Bit 3 of the register at address 0x8E is the suppress flag. When it is 1 at the overflow edge, `rst_pin_drive` stays low while `wdt_reset_req` still pulses. The other bits of that register are ignored.
- R10: External reset ends a reset-out pulse that is in progress and clears all state, including an open key pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_ext | input | 1 | External reset, active high, asynchronous |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| wdt_reset_req | output | 1 | One-clock reset request on overflow |
| rst_pin_drive | output | 1 | Stretched reset-out drive |

## Verification
The assertions assume that `mc_tick` and the write-bus signals are clean, synchronous levels that are sampled only at the clock edge. They also assume that `rst_ext` is the only reset and that the overflow check is meaningful only while `rst_ext` is low. The bench keeps to these assumptions: it changes every input one time unit after the falling clock edge and holds it steady across the next rising edge. The random phase mixes the two key bytes, arbitrary bytes, auxiliary-register writes and a 50% machine-cycle strobe. The directed phases hold the strobe high on every cycle so that each overflow window is exactly 16384 strobes long.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SFR_AW = 8;
  localparam int SFR_DW = 8;

  localparam logic [SFR_DW-1:0] KEY_OPEN  = 8'h1E;
  localparam logic [SFR_DW-1:0] KEY_CLOSE = 8'hE1;

  typedef enum logic {KEY_IDLE, KEY_HALF} key_state_e;

  // True when a count of the given width sits at its all-ones value.
  function automatic logic at_terminal(input logic [31:0] cnt, input int width);
    return cnt == ((32'h1 << width) - 32'h1);
  endfunction

  // Value loaded into the stretch counter at overflow.
  function automatic int unsigned pulse_load(input logic suppress, input int unsigned len);
    return suppress ? 0 : len;
  endfunction

  // Next key-sequencer state for a write to the key register.
  function automatic key_state_e key_next(input logic [SFR_DW-1:0] data);
    return (data == KEY_OPEN) ? KEY_HALF : KEY_IDLE;
  endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter logic [SFR_AW-1:0] KEY_ADDR = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_ext,
  input  logic              sfr_we,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  output logic              kick,
  output logic              pending
);

  key_state_e state_q;
  logic       key_hit;

  assign key_hit = sfr_we && (sfr_addr == KEY_ADDR);
  assign pending = (state_q == KEY_HALF);
  assign kick    = key_hit && pending && (sfr_wdata == KEY_CLOSE);

  always_ff @(posedge clk or posedge rst_ext) begin
    if (rst_ext)
      state_q <= KEY_IDLE;
    else if (key_hit)
      state_q <= key_next(sfr_wdata);
  end

endmodule

// File: rtl/wdt_cycle_counter.sv
module wdt_cycle_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_ext,
  input  logic             mc_tick,
  input  logic             kick,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  logic at_top;

  assign at_top = at_terminal(32'(count), CNT_W);
  // A restart on the same edge wins over the final strobe.
  assign ovf    = armed && mc_tick && at_top && !kick;

  always_ff @(posedge clk or posedge rst_ext) begin
    if (rst_ext) begin
      armed <= 1'b0;
      count <= '0;
    end else if (kick) begin
      armed <= 1'b1;
      count <= '0;
    end else if (ovf) begin
      armed <= 1'b0;
      count <= '0;
    end else if (armed && mc_tick) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_aux_flag.sv
module wdt_aux_flag
  import wdt_pkg::*;
#(
  parameter logic [SFR_AW-1:0] AUX_ADDR     = 8'h8E,
  parameter int                SUPPRESS_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_ext,
  input  logic              sfr_we,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  output logic              suppress
);

  generate
    if (SUPPRESS_BIT >= 0 && SUPPRESS_BIT < SFR_DW) begin : g_flag
      always_ff @(posedge clk or posedge rst_ext) begin
        if (rst_ext)
          suppress <= 1'b0;
        else if (sfr_we && sfr_addr == AUX_ADDR)
          suppress <= sfr_wdata[SUPPRESS_BIT];
      end
    end else begin : g_none
      assign suppress = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 98
) (
  input  logic clk,
  input  logic rst_ext,
  input  logic ovf,
  input  logic suppress,
  output logic reset_req,
  output logic drive
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] remain_q;

  always_ff @(posedge clk or posedge rst_ext) begin
    if (rst_ext) begin
      remain_q  <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= ovf;
      if (ovf)
        remain_q <= PW'(pulse_load(suppress, PULSE_LEN));
      else if (remain_q != '0)
        remain_q <= remain_q - 1'b1;
    end
  end

  assign drive = (remain_q != '0);

endmodule

// File: rtl/mcu_watchdog.sv
module mcu_watchdog
  import wdt_pkg::*;
#(
  parameter int                CNT_W        = 14,
  parameter int                PULSE_LEN    = 98,
  parameter logic [SFR_AW-1:0] KEY_ADDR     = 8'hA6,
  parameter logic [SFR_AW-1:0] AUX_ADDR     = 8'h8E,
  parameter int                SUPPRESS_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_ext,
  input  logic              mc_tick,
  input  logic              sfr_we,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  output logic              wdt_reset_req,
  output logic              rst_pin_drive
);

  // Internal events, named so the bound checker can see them.
  logic             kick;
  logic             key_pending;
  logic             wd_armed;
  logic [CNT_W-1:0] wd_count;
  logic             wd_ovf;
  logic             suppress;

  wdt_key_seq #(.KEY_ADDR(KEY_ADDR)) u_key (
    .clk       (clk),
    .rst_ext   (rst_ext),
    .sfr_we    (sfr_we),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .kick      (kick),
    .pending   (key_pending)
  );

  wdt_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_ext (rst_ext),
    .mc_tick (mc_tick),
    .kick    (kick),
    .armed   (wd_armed),
    .count   (wd_count),
    .ovf     (wd_ovf)
  );

  wdt_aux_flag #(.AUX_ADDR(AUX_ADDR), .SUPPRESS_BIT(SUPPRESS_BIT)) u_aux (
    .clk       (clk),
    .rst_ext   (rst_ext),
    .sfr_we    (sfr_we),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .suppress  (suppress)
  );

  wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk       (clk),
    .rst_ext   (rst_ext),
    .ovf       (wd_ovf),
    .suppress  (suppress),
    .reset_req (wdt_reset_req),
    .drive     (rst_pin_drive)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int                CNT_W    = 14,
  parameter logic [SFR_AW-1:0] KEY_ADDR = 8'hA6
) (
  input logic              clk,
  input logic              rst_ext,
  input logic              mc_tick,
  input logic              sfr_we,
  input logic [SFR_AW-1:0] sfr_addr,
  input logic [SFR_DW-1:0] sfr_wdata,
  input logic              kick,
  input logic              key_pending,
  input logic              wd_armed,
  input logic [CNT_W-1:0]  wd_count,
  input logic              wd_ovf,
  input logic              suppress,
  input logic              wdt_reset_req,
  input logic              rst_pin_drive
);

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst_ext)
    !wd_armed |-> wd_count == '0);  // R1
  AST_KICK_ARMS: assert property (@(posedge clk) disable iff (rst_ext)
    kick |=> wd_armed && wd_count == '0);  // R2
  AST_KICK_BEATS_OVF: assert property (@(posedge clk) disable iff (rst_ext)
    kick |-> !wd_ovf);  // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst_ext)
    wd_armed && mc_tick && !kick && !wd_ovf |=> wd_count == CNT_W'($past(wd_count) + 1'b1));  // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst_ext)
    wd_armed && !mc_tick && !kick |=> $stable(wd_count));  // R4
  AST_NO_SW_DISARM: assert property (@(posedge clk) disable iff (rst_ext)
    wd_armed && !wd_ovf |=> wd_armed);  // R5
  AST_PAIR_CANCEL: assert property (@(posedge clk) disable iff (rst_ext)
    key_pending && sfr_we && sfr_addr == KEY_ADDR && sfr_wdata != KEY_OPEN
      && sfr_wdata != KEY_CLOSE |=> !key_pending);  // R6
  AST_OVF_DISARMS: assert property (@(posedge clk) disable iff (rst_ext)
    wd_ovf |=> !wd_armed && wdt_reset_req);  // R7
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst_ext)
    wdt_reset_req |=> !wdt_reset_req);  // R7
  AST_DRIVE_FROM_OVF: assert property (@(posedge clk) disable iff (rst_ext)
    $rose(rst_pin_drive) |-> $past(wd_ovf));  // R8
  AST_SUPPRESSED: assert property (@(posedge clk) disable iff (rst_ext)
    wd_ovf && suppress |=> !rst_pin_drive);  // R9

endmodule

bind mcu_watchdog wdt_checker #(.CNT_W(CNT_W), .KEY_ADDR(KEY_ADDR)) u_chk (
  .clk           (clk),
  .rst_ext       (rst_ext),
  .mc_tick       (mc_tick),
  .sfr_we        (sfr_we),
  .sfr_addr      (sfr_addr),
  .sfr_wdata     (sfr_wdata),
  .kick          (kick),
  .key_pending   (key_pending),
  .wd_armed      (wd_armed),
  .wd_count      (wd_count),
  .wd_ovf        (wd_ovf),
  .suppress      (suppress),
  .wdt_reset_req (wdt_reset_req),
  .rst_pin_drive (rst_pin_drive)
);

// File: tb/mcu_watchdog_bench.sv
module mcu_watchdog_bench;

  localparam int TOP   = 16383;
  localparam int PLEN  = 98;
  localparam int LIMIT = 195000;

  logic       clk = 1'b0;
  logic       rst_ext = 1'b1;
  logic       mc_tick = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       wdt_reset_req;
  logic       rst_pin_drive;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference state, written from the requirements.
  bit m_armed = 0, m_open = 0, m_sup = 0, m_req = 0;
  int m_cnt = 0, m_left = 0;

  always #10 clk = ~clk;

  mcu_watchdog u_mcu_watchdog (
    .clk(clk), .rst_ext(rst_ext), .mc_tick(mc_tick), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .wdt_reset_req(wdt_reset_req), .rst_pin_drive(rst_pin_drive)
  );

  function automatic bit closes_pair(bit open, bit we, logic [7:0] a, logic [7:0] d);
    return open && we && a == 8'hA6 && d == 8'hE1;
  endfunction

  function automatic bit overflows(bit armed, int cnt, bit tick, bit restart);
    return armed && tick && cnt == TOP && !restart;
  endfunction

  always @(posedge clk or posedge rst_ext) begin
    if (rst_ext) begin
      m_armed = 0; m_open = 0; m_sup = 0; m_req = 0; m_cnt = 0; m_left = 0;
    end else begin
      bit k, o;
      k = closes_pair(m_open, sfr_we, sfr_addr, sfr_wdata);
      o = overflows(m_armed, m_cnt, mc_tick, k);
      if (sfr_we && sfr_addr == 8'hA6) m_open = (sfr_wdata == 8'h1E);
      m_req = o;
      if (o) m_left = m_sup ? 0 : PLEN;
      else if (m_left > 0) m_left--;
      if (k) begin m_armed = 1; m_cnt = 0; end
      else if (o) begin m_armed = 0; m_cnt = 0; end
      else if (m_armed && mc_tick) m_cnt++;
      if (sfr_we && sfr_addr == 8'h8E) m_sup = sfr_wdata[3];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Every cycle: outputs against the reference (R4, R7, R8).
  always @(negedge clk) begin
    cycles++;
    check(wdt_reset_req === m_req, "R7 reset_req vs reference", int'(wdt_reset_req), int'(m_req));
    check(rst_pin_drive === (m_left != 0), "R8 rst_pin_drive vs reference",
          int'(rst_pin_drive), int'(m_left != 0));
  end

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d, input bit tk);
    sfr_we = we; sfr_addr = a; sfr_wdata = d; mc_tick = tk;
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_ext = 1'b1; step(0, 0, 0, 0); step(0, 0, 0, 0);
    rst_ext = 1'b0; step(0, 0, 0, 0);
  endtask

  task automatic arm();
    step(1, 8'hA6, 8'h1E, 0);
    step(1, 8'hA6, 8'hE1, 0);
  endtask

  // Tick every cycle; return the number of ticks until the request is seen.
  task automatic ticks_to_req(input int maxn, output int n);
    n = 0;
    while (n < maxn && wdt_reset_req !== 1'b1) begin
      step(0, 0, 0, 1); n++;
    end
  endtask

  task automatic measure_drive(output int len);
    len = 0;
    while (rst_pin_drive === 1'b1 && len < 200) begin len++; step(0, 0, 0, 0); end
  endtask

  initial begin
    int n, len;
    logic [7:0] d, a;
    void'($urandom(32'd20240611));
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R1: reset state
    check(wdt_reset_req === 1'b0, "R1 reset_req low in reset", int'(wdt_reset_req), 0);
    check(rst_pin_drive === 1'b0, "R1 drive low in reset", int'(rst_pin_drive), 0);
    rst_ext = 1'b0; step(0, 0, 0, 0);
    ticks_to_req(20000, n);
    check(n == 20000, "R1 unarmed after reset, no overflow", n, 20000);

    // Random mix, checked cycle by cycle against the reference.
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 8;
      d = (r < 3) ? 8'h1E : (r < 5) ? 8'hE1 : 8'($urandom);
      r = $urandom % 8;
      a = (r < 6) ? 8'hA6 : (r == 6) ? 8'h8E : 8'($urandom);
      step($urandom % 2, a, d, $urandom % 2);
    end

    // R4/R7/R8: clean window from arming to overflow
    do_reset(); arm();
    ticks_to_req(20000, n);
    check(n == TOP + 1, "R4 ticks from arming to overflow", n, TOP + 1);
    check(rst_pin_drive === 1'b1, "R8 drive starts with request", int'(rst_pin_drive), 1);
    step(0, 0, 0, 1);
    check(wdt_reset_req === 1'b0, "R7 request one clock wide", int'(wdt_reset_req), 0);
    measure_drive(len);
    check(len == PLEN - 1, "R8 drive length after first cycle", len, PLEN - 1);
    ticks_to_req(17000, n);
    check(n == 17000, "R7 disarmed after overflow", n, 17000);

    // R2/R3: interrupted pair still arms; restart on the final strobe wins
    do_reset();
    step(1, 8'hA6, 8'h1E, 0); step(1, 8'hA6, 8'h1E, 0); step(0, 0, 0, 0);
    step(1, 8'h30, 8'h77, 0); step(1, 8'hA6, 8'hE1, 0);
    for (int i = 0; i < TOP; i++) step(0, 0, 0, 1);
    step(1, 8'hA6, 8'h1E, 0);
    step(1, 8'hA6, 8'hE1, 1);
    check(wdt_reset_req === 1'b0, "R3 restart on last strobe beats overflow", int'(wdt_reset_req), 0);
    ticks_to_req(20000, n);
    check(n == TOP + 1, "R3 restart gives a full new window (R2 armed)", n, TOP + 1);
    measure_drive(len);

    // R5/R9: writes do not disarm; suppress holds the drive low
    do_reset();
    step(1, 8'h8E, 8'hF7, 0);
    step(1, 8'h8E, 8'h08, 0); arm();
    step(1, 8'hA6, 8'h00, 1); step(1, 8'hA6, 8'hE1, 1); step(1, 8'h8E, 8'h08, 1);
    step(1, 8'hA6, 8'h55, 1);
    ticks_to_req(20000, n);
    check(n == TOP + 1 - 4, "R5 writes leave watchdog armed", n, TOP + 1 - 4);
    check(rst_pin_drive === 1'b0, "R9 drive suppressed", int'(rst_pin_drive), 0);
    step(0, 0, 0, 0);
    check(rst_pin_drive === 1'b0, "R9 drive stays low", int'(rst_pin_drive), 0);

    // R6: an unrelated byte closes the pair
    do_reset();
    step(1, 8'hA6, 8'h1E, 0); step(1, 8'hA6, 8'h5A, 0); step(1, 8'hA6, 8'hE1, 0);
    ticks_to_req(16500, n);
    check(n == 16500, "R6 cancelled pair does not arm", n, 16500);

    // R10: reset in the middle of the drive pulse
    do_reset(); arm();
    ticks_to_req(20000, n);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0);
    check(rst_pin_drive === 1'b1, "R10 pulse under way", int'(rst_pin_drive), 1);
    rst_ext = 1'b1; step(0, 0, 0, 0);
    check(rst_pin_drive === 1'b0, "R10 reset ends pulse", int'(rst_pin_drive), 0);
    rst_ext = 1'b0; step(0, 0, 0, 0);
    step(1, 8'hA6, 8'hE1, 0);
    ticks_to_req(16500, n);
    check(n == 16500, "R10 reset cleared open pair and armed state", n, 16500);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    wait (cycles >= LIMIT);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule